// File: doc/BRIEF.md
# Audio Serial Frame Transmitter

This block turns parallel audio words into a serial stereo stream. It produces one data line and one channel-select line, and it advances both on bit-clock ticks. A tick is a one-cycle strobe that marks the falling edge of the bit clock, so a receiver can capture the data on the rising edge. Every frame has two channel slots of `SLOT_BITS` bit periods each: the left slot, then the right slot. At the first bit period of each slot the block takes one word from an upstream sample queue through a valid/ready pair.

Run-time configuration inputs select the following:
- the number of significant bits per sample;
- where the sample sits inside the queue word;
- whether the most or the least significant bit goes out first;
- the framing scheme, which is one of: standard I2S with a one-bit delay, left-justified, right-justified, or a PCM-style frame sync;
- the polarity of the select line.

If the queue has no word ready when a slot begins, that slot carries zeros and a one-cycle underrun flag is raised.

Top module: `aud_tx_serializer`

## Requirements
- R1: `cfg_width_m1` holds the sample width minus one. Codes 7 to 31 select 8 to 32 bits. Codes below 7 are treated as an 8-bit width.
- R2: With `cfg_pcm`=0, `cfg_just` selects the framing. Code 0 is I2S: `ws` changes one bit period before the slot's first data bit. Code 1 is left-justified: `ws` changes in the same bit period as the first data bit. Code 2 is right-justified: the last sample bit occupies the slot's final bit period, with zeros before it. Code 3 is reserved: `sdo` stays 0 and `ws` behaves as in code 1.
- R3: With `cfg_pcm`=1, `cfg_just` is ignored. Data is placed as in left-justified mode in both slots. The unconverted `ws` is high only during the final bit period of the right slot, which is the period before each frame starts.
- R4: `cfg_lsb_first`=0 sends the sample MSB first. `cfg_lsb_first`=1 sends it LSB first.
- R5: `cfg_left_aligned`=0 takes the sample from the low bits of `smp_data`. `cfg_left_aligned`=1 takes it from the high bits.
- R6: `cfg_ws_invert`=1 inverts `ws` in every mode. With `cfg_ws_invert`=0, `ws` is 0 for the left slot and 1 for the right slot.
- R7: `sdo` and `ws` change only in the cycle after a `bclk_fall` strobe.
- R8: `smp_ready` is high only on the `bclk_fall` strobe that opens a slot. Exactly one word is consumed per slot.
- R9: If `smp_valid` is low when a slot opens, that slot sends all zeros. `underrun` is high for exactly the one cycle that follows that strobe.
- R10: After reset, `sdo`, `ws` and `underrun` are 0. The first strobe opens the left slot.
- R11: In early-placed modes (I2S, left-justified, PCM), the bit periods after the last sample bit carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_fall | input | 1 | One-cycle strobe at each falling bit-clock edge |
| cfg_width_m1 | input | $clog2(WORD_W) | Sample width minus one |
| cfg_just | input | 2 | Framing scheme: 0 I2S, 1 left, 2 right, 3 reserved |
| cfg_pcm | input | 1 | 1 selects PCM frame-sync framing |
| cfg_lsb_first | input | 1 | 1 sends the LSB first |
| cfg_left_aligned | input | 1 | 1 takes the sample from the high bits of the word |
| cfg_ws_invert | input | 1 | Inverts the select line |
| smp_data | input | WORD_W | Sample word from the queue |
| smp_valid | input | 1 | Sample word present |
| smp_ready | output | 1 | Word taken in this cycle |
| sdo | output | 1 | Serial data |
| ws | output | 1 | Channel select or frame sync |
| underrun | output | 1 | One-cycle pulse when a slot starts empty |

## Verification
The embedded assertions check four things on every cycle:
- the outputs hold still between strobes;
- `smp_ready` appears only on a strobe;
- `underrun` follows an unserved slot opening;
- the slot counter wraps and toggles the channel in step.

The reserved justification code is also checked continuously for silence. Correct bit order, placement in the slot, the one-bit I2S delay, right-justified padding, the PCM sync position, select inversion and width clamping can only be shown by the bench's scenarios. In those scenarios every bit period is compared against a model built from the requirements.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [1:0] {
      JUST_I2S   = 2'd0,
      JUST_LEFT  = 2'd1,
      JUST_RIGHT = 2'd2,
      JUST_RSVD  = 2'd3
   } just_e;

   typedef enum logic [1:0] {
      PL_EARLY = 2'd0,
      PL_LATE  = 2'd1,
      PL_OFF   = 2'd2
   } place_e;

   localparam int MIN_WIDTH = 8;

endpackage

// File: rtl/aud_tx_slot_timer.sv
module aud_tx_slot_timer #(
   parameter int SLOT_BITS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   output logic [$clog2(SLOT_BITS)-1:0] pos_n,
   output logic                         chan_n,
   output logic                         slot_start
);
   localparam int PW = $clog2(SLOT_BITS);
   localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

   logic [PW-1:0] pos_q;
   logic          chan_q;

   always_comb begin
      if (pos_q == LAST) begin
         pos_n  = '0;
         chan_n = ~chan_q;
      end else begin
         pos_n  = pos_q + 1'b1;
         chan_n = chan_q;
      end
   end

   assign slot_start = tick && (pos_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= LAST;
         chan_q <= 1'b1;
      end else if (tick) begin
         pos_q  <= pos_n;
         chan_q <= chan_n;
      end
   end

   // R8: a slot opening moves to position zero of the other channel
   a_r8_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |=> (pos_q == '0) && (chan_q != $past(chan_q)));

endmodule

// File: rtl/aud_tx_bit_picker.sv
module aud_tx_bit_picker
   import aud_tx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int SLOT_BITS = 32
) (
   input  logic [WORD_W-1:0]            word,
   input  logic [$clog2(WORD_W):0]      width,
   input  logic                         lsb_first,
   input  logic                         left_aligned,
   input  place_e                       place,
   input  logic [$clog2(SLOT_BITS)-1:0] pos,
   output logic                         bit_out
);
   localparam int IW = $clog2(WORD_W);

   logic [WORD_W-1:0] keep_mask;
   logic [WORD_W-1:0] field;
   logic [WORD_W-1:0] field_rev;
   logic [WORD_W-1:0] seq;

   always_comb begin
      keep_mask = ~({WORD_W{1'b1}} << width);
      if (left_aligned) field = word >> (WORD_W - int'(width));
      else              field = word & keep_mask;
   end

   genvar gi;
   generate
      for (gi = 0; gi < WORD_W; gi++) begin : g_rev
         assign field_rev[gi] = field[WORD_W-1-gi];
      end
   endgenerate

   always_comb begin
      if (lsb_first) seq = field;
      else           seq = field_rev >> (WORD_W - int'(width));
   end

   always_comb begin
      int   p_i;
      int   w_i;
      int   k_i;
      logic hit;
      p_i = int'(pos);
      w_i = int'(width);
      hit = 1'b0;
      k_i = 0;
      case (place)
         PL_EARLY: begin
            hit = (p_i < w_i);
            k_i = p_i;
         end
         PL_LATE: begin
            hit = (p_i >= SLOT_BITS - w_i);
            k_i = p_i - (SLOT_BITS - w_i);
         end
         default: begin
            hit = 1'b0;
            k_i = 0;
         end
      endcase
      bit_out = hit & seq[k_i[IW-1:0]];
   end

endmodule

// File: rtl/aud_tx_ws_gen.sv
module aud_tx_ws_gen
   import aud_tx_pkg::*;
#(
   parameter int SLOT_BITS = 32
) (
   input  logic                         pcm,
   input  just_e                        just,
   input  logic                         invert,
   input  logic [$clog2(SLOT_BITS)-1:0] pos_n,
   input  logic                         chan_n,
   output logic                         ws_bit
);
   localparam int PW = $clog2(SLOT_BITS);
   localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

   logic raw;

   always_comb begin
      if (pcm)                   raw = chan_n && (pos_n == LAST);
      else if (just == JUST_I2S) raw = (pos_n == LAST) ? ~chan_n : chan_n;
      else                       raw = chan_n;
      ws_bit = raw ^ invert;
   end

endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
   import aud_tx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int SLOT_BITS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bclk_fall,
   input  logic [$clog2(WORD_W)-1:0]  cfg_width_m1,
   input  logic [1:0]                 cfg_just,
   input  logic                       cfg_pcm,
   input  logic                       cfg_lsb_first,
   input  logic                       cfg_left_aligned,
   input  logic                       cfg_ws_invert,
   input  logic [WORD_W-1:0]          smp_data,
   input  logic                       smp_valid,
   output logic                       smp_ready,
   output logic                       sdo,
   output logic                       ws,
   output logic                       underrun
);
   localparam int CW = $clog2(WORD_W) + 1;
   localparam int PW = $clog2(SLOT_BITS);

   generate
      if (WORD_W < MIN_WIDTH) begin : g_bad_word
         $error("WORD_W below minimum sample width");
      end
      if (SLOT_BITS < WORD_W) begin : g_bad_slot
         $error("SLOT_BITS must hold a full word");
      end
   endgenerate

   logic [CW-1:0]     width_eff;
   just_e             just_sel;
   place_e            place;
   logic [PW-1:0]     pos_n;
   logic              chan_n;
   logic              slot_start;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] cur_word;
   logic              bit_nxt;
   logic              ws_nxt;
   logic              sdo_q;
   logic              ws_q;
   logic              under_q;

   assign just_sel = just_e'(cfg_just);

   always_comb begin
      if (int'(cfg_width_m1) < MIN_WIDTH - 1) width_eff = CW'(MIN_WIDTH);
      else                                    width_eff = CW'(cfg_width_m1) + CW'(1);
   end

   always_comb begin
      if (cfg_pcm)                     place = PL_EARLY;
      else begin
         case (just_sel)
            JUST_I2S, JUST_LEFT: place = PL_EARLY;
            JUST_RIGHT:          place = PL_LATE;
            default:             place = PL_OFF;
         endcase
      end
   end

   aud_tx_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (bclk_fall),
      .pos_n      (pos_n),
      .chan_n     (chan_n),
      .slot_start (slot_start)
   );

   always_comb begin
      if (slot_start) cur_word = smp_valid ? smp_data : '0;
      else            cur_word = word_q;
   end

   aud_tx_bit_picker #(.WORD_W(WORD_W), .SLOT_BITS(SLOT_BITS)) u_pick (
      .word         (cur_word),
      .width        (width_eff),
      .lsb_first    (cfg_lsb_first),
      .left_aligned (cfg_left_aligned),
      .place        (place),
      .pos          (pos_n),
      .bit_out      (bit_nxt)
   );

   aud_tx_ws_gen #(.SLOT_BITS(SLOT_BITS)) u_ws (
      .pcm    (cfg_pcm),
      .just   (just_sel),
      .invert (cfg_ws_invert),
      .pos_n  (pos_n),
      .chan_n (chan_n),
      .ws_bit (ws_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         sdo_q   <= 1'b0;
         ws_q    <= 1'b0;
         under_q <= 1'b0;
      end else begin
         under_q <= slot_start && !smp_valid;
         if (bclk_fall) begin
            sdo_q <= bit_nxt;
            ws_q  <= ws_nxt;
            if (slot_start) word_q <= cur_word;
         end
      end
   end

   assign smp_ready = slot_start;
   assign sdo       = sdo_q;
   assign ws        = ws_q;
   assign underrun  = under_q;

   // R7: outputs hold between bit-clock strobes
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_fall |=> ($stable(sdo) && $stable(ws)));

   // R8: a word is only taken on a strobe
   a_r8_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |-> bclk_fall);

   // R9: underrun only follows an unserved slot opening
   a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> ($past(smp_ready) && !$past(smp_valid)));

   // R9: the flag is a single-cycle pulse
   a_r9_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

   // R2: the reserved code keeps the data line quiet
   a_r2_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_fall && !cfg_pcm && cfg_just == 2'd3) |=> !sdo);

endmodule

// File: tb/aud_tx_serializer_tb.sv
module aud_tx_serializer_tb;
   localparam int S = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_fall = 1'b0;
   logic [4:0]  cfg_width_m1 = '0;
   logic [1:0]  cfg_just = '0;
   logic        cfg_pcm = 1'b0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_left_aligned = 1'b0;
   logic        cfg_ws_invert = 1'b0;
   logic [31:0] smp_data = '0;
   logic        smp_valid = 1'b0;
   logic        smp_ready;
   logic        sdo;
   logic        ws;
   logic        underrun;

   always #10 clk = ~clk;

   aud_tx_serializer #(.WORD_W(32), .SLOT_BITS(S)) u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .bclk_fall        (bclk_fall),
      .cfg_width_m1     (cfg_width_m1),
      .cfg_just         (cfg_just),
      .cfg_pcm          (cfg_pcm),
      .cfg_lsb_first    (cfg_lsb_first),
      .cfg_left_aligned (cfg_left_aligned),
      .cfg_ws_invert    (cfg_ws_invert),
      .smp_data         (smp_data),
      .smp_valid        (smp_valid),
      .smp_ready        (smp_ready),
      .sdo              (sdo),
      .ws               (ws),
      .underrun         (underrun)
   );

   typedef struct {
      logic  sdo;
      logic  ws;
      logic  und;
      string tag;
   } exp_t;

   exp_t        expq[$];
   logic [31:0] srcq[$];
   int          n_checks = 0;
   int          n_fail = 0;
   bit          run = 0;
   int          tcnt = 0;
   logic        tick_d = 1'b0;
   bit          have_last = 0;
   logic        last_sdo, last_ws;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp_v, $time);
      end
   endtask

   // sample source
   always @(posedge clk)
      if (smp_valid && smp_ready && srcq.size() > 0) void'(srcq.pop_front());
   always @(negedge clk) begin
      smp_valid = (srcq.size() > 0);
      smp_data  = (srcq.size() > 0) ? srcq[0] : 32'h0;
   end

   // bit-clock strobe every 4 cycles
   always @(negedge clk) begin
      if (run) begin
         tcnt++;
         bclk_fall = (tcnt % 4 == 0);
      end else begin
         tcnt = 0;
         bclk_fall = 1'b0;
      end
   end

   always @(posedge clk) tick_d <= bclk_fall;

   // monitor
   always @(negedge clk) begin
      if (run && tick_d) begin
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check({e.tag, " sdo"}, {31'b0, sdo}, {31'b0, e.sdo});
            check({e.tag, " ws"}, {31'b0, ws}, {31'b0, e.ws});
            check("R9 underrun", {31'b0, underrun}, {31'b0, e.und});
         end
         last_sdo  = sdo;
         last_ws   = ws;
         have_last = 1;
      end else if (run && have_last) begin
         check("R7 hold", {30'b0, sdo, ws}, {30'b0, last_sdo, last_ws});
      end
   end

   function automatic logic exp_bit(logic [31:0] w, int wid, logic [1:0] js, logic pcm,
                                    logic lsbf, logic lal, int p);
      logic sb[32];
      int   k;
      for (int i = 0; i < 32; i++) sb[i] = 1'b0;
      for (int i = 0; i < wid; i++) sb[i] = lal ? w[32-wid+i] : w[i];
      if (!pcm && js == 2'd3) return 1'b0;
      if (pcm || js != 2'd2) begin
         if (p >= wid) return 1'b0;
         k = p;
      end else begin
         if (p < S - wid) return 1'b0;
         k = p - (S - wid);
      end
      return lsbf ? sb[k] : sb[wid-1-k];
   endfunction

   function automatic logic exp_ws(int ch, int p, logic [1:0] js, logic pcm, logic inv);
      logic r;
      if (pcm)              r = (ch == 1) && (p == S - 1);
      else if (js == 2'd0)  r = (p == S - 1) ? (ch == 0) : (ch == 1);
      else                  r = (ch == 1);
      return r ^ inv;
   endfunction

   task automatic run_case(input string tag, input logic [4:0] wc, input logic [1:0] js,
                           input logic pcm, input logic lsbf, input logic lal, input logic inv,
                           input int nwords, input int nslots, input logic [31:0] seed);
      logic [31:0] words[$];
      logic [31:0] w;
      int          wid;
      int          lim;
      @(negedge clk);
      run = 0;
      rst_n = 1'b0;
      srcq.delete();
      expq.delete();
      have_last = 0;
      repeat (2) @(negedge clk);
      cfg_width_m1 = wc; cfg_just = js; cfg_pcm = pcm;
      cfg_lsb_first = lsbf; cfg_left_aligned = lal; cfg_ws_invert = inv;
      rst_n = 1'b1;
      wid = (int'(wc) < 7) ? 8 : int'(wc) + 1;
      w = seed;
      for (int i = 0; i < nwords; i++) begin
         w = w * 32'h0019660D + 32'h3C6EF35F;
         words.push_back(w);
         srcq.push_back(w);
      end
      for (int s = 0; s < nslots; s++) begin
         for (int p = 0; p < S; p++) begin
            exp_t e;
            e.sdo = (s < nwords) ? exp_bit(words[s], wid, js, pcm, lsbf, lal, p) : 1'b0;
            e.ws  = exp_ws(s % 2, p, js, pcm, inv);
            e.und = (p == 0) && (s >= nwords);
            e.tag = tag;
            expq.push_back(e);
         end
      end
      @(negedge clk);
      run = 1;
      lim = nslots * S * 4 + 100;
      while (expq.size() > 0 && lim > 0) begin
         @(negedge clk);
         lim--;
      end
      @(negedge clk);
      run = 0;
      check({tag, " R8 words consumed"}, nwords - srcq.size(),
            (nwords < nslots) ? nwords : nslots);
      check({tag, " stream drained"}, expq.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 sdo", {31'b0, sdo}, 0);
      check("R10 ws", {31'b0, ws}, 0);
      check("R10 underrun", {31'b0, underrun}, 0);
      check("R10 ready", {31'b0, smp_ready}, 0);
      // I2S, 16 bit, low bits, MSB first (R1, R2, R4, R10 first slot is left)
      run_case("R2/R4/R10 i2s16", 5'd15, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 4, 32'h1234);
      // left-justified 24 bit taken from high bits, trailing zeros, one word per slot
      run_case("R2/R5/R11 lj24", 5'd23, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6, 4, 32'hBEEF);
      // right-justified 20 bit LSB first
      run_case("R2/R4 rj20", 5'd19, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4, 4, 32'h77);
      // PCM framing; just code 2 must be ignored
      run_case("R3 pcm16", 5'd15, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4, 4, 32'h5A5A);
      // inverted select, full 32-bit width, left-justified
      run_case("R6/R1 lj32 inv", 5'd31, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4, 4, 32'hC0DE);
      // inverted select in I2S mode
      run_case("R6 i2s inv", 5'd15, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4, 4, 32'h99);
      // reserved justification code
      run_case("R2 reserved", 5'd15, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4, 4, 32'hFACE);
      // underrun: only two words for four slots
      run_case("R9 underrun", 5'd15, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 4, 32'h4321);
      // width code below minimum clamps to 8, high bits
      run_case("R1/R5 clamp8", 5'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4, 4, 32'hABCD);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule